// File: doc/BRIEF.md
# Descriptor Pointer Sequencer

This block walks the descriptor chains of one DMA channel. Each side of the channel, source and destination, keeps its own 49-bit current-descriptor pointer. On command, the block reads the 16-byte descriptor at that pointer through a word-wide memory read port and decodes it into buffer address, size and attribute fields. It then moves the pointer on, either to the next slot of a contiguous array or to a link stored just behind the descriptor.

A start command loads both current pointers from the start values and fetches the first destination descriptor at once. After that, a destination refill is requested from outside whenever the current destination buffer has run dry while data is still pending. Source fetches are commanded explicitly. With register mode selected, the descriptor comes from four register words supplied on the ports instead of memory. A misaligned pointer yields an all-zero descriptor, a sticky channel error and an error pulse for the side concerned.

Top module: `desc_ptr_seq`

## Requirements
- R1: A completed fetch pulses `desc_valid` for one cycle. It presents bytes 0-7 of the descriptor as `desc_addr` (word at pointer+4 in bits 63:32), the low 30 bits of the word at pointer+8 as `desc_size`, and bits 0, 1 and 2 of the word at pointer+12 as `desc_coherent`, `desc_linked` and `desc_irq`.
- R2: `desc_cmd` carries bits 4:3 of the attribute word for a source descriptor (1 halt, 2 stop) and always reads 0 for a destination descriptor.
- R3: A pointer whose low 4 bits are not zero causes no memory read. The result is an all-zero descriptor with `desc_valid`, a set `chan_err`, one pulse on `src_fetch_err` or `dst_fetch_err` for the side, and an unchanged pointer.
- R4: When the attribute type bit is 0, the pointer of the fetched side advances by 16 once the fetch completes.
- R5: When the type bit is 1, the block reads the two words at pointer+16 and pointer+20, after the four descriptor words. The new pointer is their 64-bit little-endian value cut to 49 bits.
- R6: Pointers are 49 bits wide, shown as a 32-bit low word and a 17-bit high word, and wrap modulo 2^49.
- R7: With `reg_mode` high, a fetch takes its descriptor from `src_reg_words` or `dst_reg_words` (word 0 in bits 31:0), raises no memory request and leaves the pointer unchanged.
- R8: `cmd_start` loads both pointers from the start inputs, clears `chan_err`, and then fetches a destination descriptor and advances the destination pointer.
- R9: A destination fetch starts when `dst_left_zero` and `data_pending` are both high in memory mode. It does not start in register mode or without pending data.
- R10: `busy` is high from the cycle after a command is accepted until the result is presented. Commands arriving while busy are ignored. When several commands arrive together, start wins over source fetch, which wins over refill.
- R11: Memory reads go one 32-bit word per `rd_valid` beat, at pointer+4k in increasing k, with `rd_req` and `rd_addr` held until the beat arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_mode | input | 1 | Descriptor taken from register words instead of memory |
| cmd_start | input | 1 | Load pointers from start values and fetch destination |
| cmd_src | input | 1 | Fetch the source descriptor |
| dst_left_zero | input | 1 | Destination remaining size has reached zero |
| data_pending | input | 1 | Data still waiting to be written |
| src_start_lo | input | 32 | Source start pointer, low word |
| src_start_hi | input | 17 | Source start pointer, high bits |
| dst_start_lo | input | 32 | Destination start pointer, low word |
| dst_start_hi | input | 17 | Destination start pointer, high bits |
| src_reg_words | input | 128 | Register-mode source descriptor |
| dst_reg_words | input | 128 | Register-mode destination descriptor |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 49 | Memory read byte address |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data word |
| busy | output | 1 | Fetch in progress |
| chan_err | output | 1 | Sticky misaligned-descriptor error |
| src_fetch_err | output | 1 | Source descriptor error pulse |
| dst_fetch_err | output | 1 | Destination descriptor error pulse |
| src_cur_lo | output | 32 | Source current pointer, low word |
| src_cur_hi | output | 17 | Source current pointer, high bits |
| dst_cur_lo | output | 32 | Destination current pointer, low word |
| dst_cur_hi | output | 17 | Destination current pointer, high bits |
| desc_valid | output | 1 | Decoded descriptor presented this cycle |
| desc_side | output | 1 | 0 source, 1 destination |
| desc_addr | output | 64 | Buffer address |
| desc_size | output | 30 | Buffer size |
| desc_coherent | output | 1 | Coherent attribute |
| desc_linked | output | 1 | Type bit: 1 linked, 0 contiguous |
| desc_irq | output | 1 | Interrupt-on-completion attribute |
| desc_cmd | output | 2 | Source command field |

## Verification
The assertions assume that `reg_mode` stays stable from the moment a command is accepted until its result is presented. They also assume that `rd_valid` arrives only while `rd_req` is high. The stimulus changes `reg_mode` only between operations, while the block is idle. The memory model answers only an outstanding request, after a random delay of zero to two cycles. Refill inputs are held until the result appears and dropped in that same cycle, so a completed refill never retriggers by accident.

// File: rtl/desc_ptr_seq.sv
module desc_ptr_seq #(
  parameter int PTR_W = 49
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_mode,
  input  logic               cmd_start,
  input  logic               cmd_src,
  input  logic               dst_left_zero,
  input  logic               data_pending,
  input  logic [31:0]        src_start_lo,
  input  logic [PTR_W-33:0]  src_start_hi,
  input  logic [31:0]        dst_start_lo,
  input  logic [PTR_W-33:0]  dst_start_hi,
  input  logic [127:0]       src_reg_words,
  input  logic [127:0]       dst_reg_words,
  output logic               rd_req,
  output logic [PTR_W-1:0]   rd_addr,
  input  logic               rd_valid,
  input  logic [31:0]        rd_data,
  output logic               busy,
  output logic               chan_err,
  output logic               src_fetch_err,
  output logic               dst_fetch_err,
  output logic [31:0]        src_cur_lo,
  output logic [PTR_W-33:0]  src_cur_hi,
  output logic [31:0]        dst_cur_lo,
  output logic [PTR_W-33:0]  dst_cur_hi,
  output logic               desc_valid,
  output logic               desc_side,
  output logic [63:0]        desc_addr,
  output logic [29:0]        desc_size,
  output logic               desc_coherent,
  output logic               desc_linked,
  output logic               desc_irq,
  output logic [1:0]         desc_cmd
);

  localparam int HI_W = PTR_W - 32;
  localparam logic [PTR_W-1:0] STEP = PTR_W'(16);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_READ} st_t;

  st_t              st;
  logic             side;
  logic [2:0]       beat;
  logic [31:0]      w0, w1, w2, w3, w4;
  logic [PTR_W-1:0] sp, dp;
  logic [127:0]     ow;
  logic             oside, ovalid, err, serr, derr;

  logic [PTR_W-1:0] cur;
  logic [63:0]      link;
  logic             refill;

  assign cur     = side ? dp : sp;
  assign link    = {rd_data, w4};
  assign refill  = dst_left_zero & data_pending & ~reg_mode;

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_READ);
  assign rd_addr = cur + PTR_W'({beat, 2'b00});

  assign chan_err      = err;
  assign src_fetch_err = serr;
  assign dst_fetch_err = derr;
  assign src_cur_lo    = sp[31:0];
  assign src_cur_hi    = sp[PTR_W-1:32];
  assign dst_cur_lo    = dp[31:0];
  assign dst_cur_hi    = dp[PTR_W-1:32];

  assign desc_valid    = ovalid;
  assign desc_side     = oside;
  assign desc_addr     = ow[63:0];
  assign desc_size     = ow[93:64];
  assign desc_coherent = ow[96];
  assign desc_linked   = ow[97];
  assign desc_irq      = ow[98];
  assign desc_cmd      = oside ? 2'b00 : ow[100:99];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      side   <= 1'b0;
      beat   <= '0;
      w0     <= '0;
      w1     <= '0;
      w2     <= '0;
      w3     <= '0;
      w4     <= '0;
      sp     <= '0;
      dp     <= '0;
      ow     <= '0;
      oside  <= 1'b0;
      ovalid <= 1'b0;
      err    <= 1'b0;
      serr   <= 1'b0;
      derr   <= 1'b0;
    end else begin
      ovalid <= 1'b0;
      serr   <= 1'b0;
      derr   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_start) begin
            sp   <= {src_start_hi, src_start_lo};
            dp   <= {dst_start_hi, dst_start_lo};
            err  <= 1'b0;
            side <= 1'b1;
            st   <= S_CHECK;
          end else if (cmd_src) begin
            side <= 1'b0;
            st   <= S_CHECK;
          end else if (refill) begin
            side <= 1'b1;
            st   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (reg_mode) begin
            ow     <= side ? dst_reg_words : src_reg_words;
            oside  <= side;
            ovalid <= 1'b1;
            st     <= S_IDLE;
          end else if (cur[3:0] != 4'h0) begin
            ow     <= '0;
            oside  <= side;
            ovalid <= 1'b1;
            err    <= 1'b1;
            serr   <= ~side;
            derr   <= side;
            st     <= S_IDLE;
          end else begin
            beat <= '0;
            st   <= S_READ;
          end
        end
        S_READ: begin
          if (rd_valid) begin
            beat <= beat + 3'd1;
            case (beat)
              3'd0: w0 <= rd_data;
              3'd1: w1 <= rd_data;
              3'd2: w2 <= rd_data;
              3'd3: begin
                w3 <= rd_data;
                if (!rd_data[1]) begin
                  ow     <= {rd_data, w2, w1, w0};
                  oside  <= side;
                  ovalid <= 1'b1;
                  st     <= S_IDLE;
                  if (side) dp <= dp + STEP;
                  else      sp <= sp + STEP;
                end
              end
              3'd4: w4 <= rd_data;
              default: begin
                ow     <= {w3, w2, w1, w0};
                oside  <= side;
                ovalid <= 1'b1;
                st     <= S_IDLE;
                if (side) dp <= link[PTR_W-1:0];
                else      sp <= link[PTR_W-1:0];
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_ptr_seq_chk.sv
module desc_ptr_seq_chk #(
  parameter int PTR_W = 49
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_mode,
  input logic              cmd_start,
  input logic              rd_req,
  input logic [PTR_W-1:0]  rd_addr,
  input logic              busy,
  input logic              chan_err,
  input logic              src_fetch_err,
  input logic              dst_fetch_err,
  input logic [31:0]       src_cur_lo,
  input logic [PTR_W-33:0] src_cur_hi,
  input logic              desc_valid,
  input logic              desc_side,
  input logic [63:0]       desc_addr,
  input logic [29:0]       desc_size,
  input logic              desc_linked,
  input logic [1:0]        desc_cmd
);

  logic [PTR_W-1:0] sp_now;
  assign sp_now = {src_cur_hi, src_cur_lo};

  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> $stable(sp_now));

  p_word_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  p_dst_nocmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_side) |-> (desc_cmd == 2'b00));

  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_fetch_err || dst_fetch_err) |->
      (desc_valid && chan_err && desc_addr == 64'h0 && desc_size == 30'h0));

  p_err_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_fetch_err || dst_fetch_err) |-> (desc_side == dst_fetch_err));

  p_no_req_regmode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !rd_req) |=> !rd_req);

  p_contig_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_side && !desc_linked && !src_fetch_err && !$past(reg_mode))
      |-> (sp_now == $past(sp_now) + PTR_W'(16)));

endmodule

bind desc_ptr_seq desc_ptr_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .cmd_start(cmd_start),
  .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy), .chan_err(chan_err),
  .src_fetch_err(src_fetch_err), .dst_fetch_err(dst_fetch_err),
  .src_cur_lo(src_cur_lo), .src_cur_hi(src_cur_hi),
  .desc_valid(desc_valid), .desc_side(desc_side), .desc_addr(desc_addr),
  .desc_size(desc_size), .desc_linked(desc_linked), .desc_cmd(desc_cmd)
);

// File: tb/desc_ptr_seq_tb.sv
`timescale 1ns/1ps
module desc_ptr_seq_tb;
  logic clk = 0, rst_n = 0;
  logic reg_mode = 0, cmd_start = 0, cmd_src = 0, dst_left_zero = 0, data_pending = 0;
  logic [31:0] src_start_lo = 0, dst_start_lo = 0;
  logic [16:0] src_start_hi = 0, dst_start_hi = 0;
  logic [127:0] src_reg_words = 0, dst_reg_words = 0;
  logic rd_req, rd_valid = 0, busy, chan_err, src_fetch_err, dst_fetch_err;
  logic [48:0] rd_addr;
  logic [31:0] rd_data = 0, src_cur_lo, dst_cur_lo;
  logic [16:0] src_cur_hi, dst_cur_hi;
  logic desc_valid, desc_side, desc_coherent, desc_linked, desc_irq;
  logic [63:0] desc_addr;
  logic [29:0] desc_size;
  logic [1:0] desc_cmd;

  always #2 clk = ~clk;

  desc_ptr_seq u_dut (.*);

  logic [31:0] mem [0:1023];
  logic [48:0] ms, md, exp_base;
  bit merr, addr_bad;
  int beats, lat, total, fails;

  function automatic logic [31:0] wat(input logic [48:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        rd_valid = 0;
      end else if (rd_req) begin
        if (lat == 0) begin
          if (rd_addr !== exp_base + 49'(4 * beats)) addr_bad = 1;
          rd_data = wat(rd_addr);
          rd_valid = 1;
          beats++;
          lat = $urandom % 3;
        end else lat--;
      end
    end
  end

  task automatic wait_result(input bit side, input bit regm, input logic [48:0] p);
    logic [127:0] wd;
    logic [48:0] np;
    bit e, seen;
    int eb;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (desc_valid) begin seen = 1; break; end
    end
    dst_left_zero = 0; data_pending = 0;
    chk(seen, "R1 result arrives", 64'(seen), 64'd1);
    if (!seen) return;
    e = 0; eb = 0; np = p;
    if (regm) wd = side ? dst_reg_words : src_reg_words;
    else if (p[3:0] != 0) begin wd = '0; e = 1; end
    else begin
      wd = {wat(p + 12), wat(p + 8), wat(p + 4), wat(p)};
      if (wd[97]) begin np = 49'({wat(p + 20), wat(p + 16)}); eb = 6; end
      else begin np = p + 49'd16; eb = 4; end
    end
    if (side) md = np; else ms = np;
    merr = merr | e;
    chk(desc_side == side, "R1 side", 64'(desc_side), 64'(side));
    chk(desc_addr == wd[63:0], "R1 addr", desc_addr, wd[63:0]);
    chk(desc_size == wd[93:64], "R1 size", 64'(desc_size), 64'(wd[93:64]));
    chk({desc_irq, desc_linked, desc_coherent} == wd[98:96], "R1 attr",
        64'({desc_irq, desc_linked, desc_coherent}), 64'(wd[98:96]));
    chk(desc_cmd == (side ? 2'b00 : wd[100:99]), "R2 cmd", 64'(desc_cmd),
        64'(side ? 2'b00 : wd[100:99]));
    chk({src_fetch_err, dst_fetch_err} == {e & ~side, e & side}, "R3 err pulse",
        64'({src_fetch_err, dst_fetch_err}), 64'({e & ~side, e & side}));
    chk(chan_err == merr, "R3 chan_err", 64'(chan_err), 64'(merr));
    chk({src_cur_hi, src_cur_lo} == ms, "R4 R5 R6 src ptr", 64'({src_cur_hi, src_cur_lo}), 64'(ms));
    chk({dst_cur_hi, dst_cur_lo} == md, "R4 R5 R6 dst ptr", 64'({dst_cur_hi, dst_cur_lo}), 64'(md));
    chk(beats == eb, "R5 R7 R11 beat count", 64'(beats), 64'(eb));
    chk(!addr_bad, "R11 read addresses", 64'(addr_bad), 64'd0);
  endtask

  task automatic op_start(input logic [48:0] ss, input logic [48:0] sd, input bit regm, input bit with_src);
    @(negedge clk);
    reg_mode = regm;
    src_reg_words = {$urandom, $urandom, $urandom, $urandom};
    dst_reg_words = {$urandom, $urandom, $urandom, $urandom};
    {src_start_hi, src_start_lo} = ss;
    {dst_start_hi, dst_start_lo} = sd;
    beats = 0; addr_bad = 0; exp_base = sd;
    ms = ss; md = sd; merr = 0;
    cmd_start = 1; cmd_src = with_src;
    @(negedge clk);
    cmd_start = 0; cmd_src = 0;
    wait_result(1'b1, regm, sd);   // R8, R10 priority
  endtask

  task automatic op_src(input bit regm, input bit intrude);
    logic [48:0] p;
    @(negedge clk);
    reg_mode = regm;
    src_reg_words = {$urandom, $urandom, $urandom, $urandom};
    p = ms; beats = 0; addr_bad = 0; exp_base = p;
    cmd_src = 1;
    @(negedge clk);
    cmd_src = 0;
    chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
    if (intrude && !regm && p[3:0] == 0) begin
      {src_start_hi, src_start_lo} = 49'h1234_5670;
      {dst_start_hi, dst_start_lo} = 49'h0ABC_DEF0;
      cmd_start = 1; cmd_src = 1; dst_left_zero = 1; data_pending = 1;
      @(negedge clk);
      cmd_start = 0; cmd_src = 0; dst_left_zero = 0; data_pending = 0;
    end
    wait_result(1'b0, regm, p);
  endtask

  task automatic op_refill(input bit regm);
    logic [48:0] p;
    @(negedge clk);
    reg_mode = regm;
    dst_reg_words = {$urandom, $urandom, $urandom, $urandom};
    p = md; beats = 0; addr_bad = 0; exp_base = p;
    dst_left_zero = 1; data_pending = 1;
    wait_result(1'b1, regm, p);    // R9
  endtask

  task automatic no_fetch(input bit regm, input bit pend);
    bit any;
    @(negedge clk);
    reg_mode = regm; dst_left_zero = 1; data_pending = pend; any = 0;
    repeat (8) begin
      @(negedge clk);
      any |= busy | desc_valid;
    end
    dst_left_zero = 0; data_pending = 0;
    chk(!any, "R9 refill suppressed", 64'(any), 64'd0);
  endtask

  function automatic logic [48:0] rand_ptr();
    logic [48:0] v;
    v = {17'($urandom), 32'($urandom)};
    if ($urandom % 8 != 0) v[3:0] = 0;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1357);
    for (int i = 0; i < 1024; i++) begin
      mem[i] = $urandom;
      if (i % 4 == 0 && $urandom % 8 != 0) mem[i][3:0] = 0;
      if (i % 4 == 1) mem[i] = mem[i] & 32'h1FFFF;
    end
    ms = 0; md = 0; merr = 0; lat = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !desc_valid && !chan_err, "R10 reset idle",
        64'({busy, rd_req, desc_valid, chan_err}), 64'd0);
    chk({src_cur_hi, src_cur_lo, dst_cur_hi, dst_cur_lo} == 0, "R6 reset ptrs",
        64'({src_cur_hi, src_cur_lo}), 64'd0);
    rst_n = 1;
    // directed: contiguous start, linked src, misaligned, wrap, register mode
    mem[3][1] = 0; mem[7][1] = 1; mem[8] = 32'h0000_0104; mem[9] = 0;
    op_start(49'h10, 49'h0, 1'b0, 1'b0);       // R8, R4
    op_src(1'b0, 1'b0);                         // R5 linked at 0x10 -> 0x104 (misaligned)
    op_src(1'b0, 1'b0);                         // R3 misaligned src
    op_start(49'h40, 49'h3, 1'b0, 1'b0);        // R3 misaligned dst
    mem[1023][1] = 0;
    op_start(49'h0, 49'h1_FFFF_FFFF_FFF0, 1'b0, 1'b0);  // R6 wrap to zero
    chk({dst_cur_hi, dst_cur_lo} == 0, "R6 wrap", 64'({dst_cur_hi, dst_cur_lo}), 64'd0);
    op_start(49'h20, 49'h30, 1'b1, 1'b1);       // R7 R10 register mode, priority
    op_src(1'b1, 1'b0);                         // R7
    no_fetch(1'b1, 1'b1);                       // R9 reg mode
    reg_mode = 0;
    op_start(49'h80, 49'h100, 1'b0, 1'b1);      // R10 priority in memory mode
    no_fetch(1'b0, 1'b0);                       // R9 nothing pending
    mem[35][1] = 0;
    ms = {src_cur_hi, src_cur_lo};
    op_start(49'h80, 49'h200, 1'b0, 1'b0);
    op_src(1'b0, 1'b1);                         // R10 commands ignored while busy
    op_refill(1'b0);                            // R9
    for (int n = 0; n < 150; n++) begin
      int k;
      bit rm;
      k = $urandom % 4;
      rm = ($urandom % 4 == 0);
      if (k == 0) op_start(rand_ptr(), rand_ptr(), rm, $urandom % 2 == 1);
      else if (k == 1) op_src(rm, $urandom % 3 == 0);
      else op_refill(1'b0);
    end
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule